// File: doc/BRIEF.md
# Sixteen-bit multi-cycle RISC core

This block is a compact 16-bit processor. Each instruction takes several clock cycles, and a small state machine steps it through fetch, decode and a short sequence of execution steps. A single memory port carries both instruction fetches and data loads and stores. The memory is word-addressed, and a write to it takes effect at the clock edge while the write enable is high. Reads are combinational, so the word at the presented address is available in the same cycle.

A single adder/logic unit does every piece of arithmetic: it increments the program counter, forms the branch target, compares the branch operands and computes data results. Values pass between cycles through holding registers for the instruction, the loaded memory word, the two register operands and the ALU result. The controller is a separate block inside the core. It decodes the opcode held in the instruction register and drives all selects and enables.

Every instruction word has four 4-bit fields: the opcode in [15:12], rs in [11:8], rt in [7:4], and a third operand in [3:0]. The third operand is rd for register operations, and a signed immediate or branch offset for the other formats. A jump uses bits [11:0] as an absolute word address.

Top module: `mc_core16`

## Requirements
- R1: While rst_n is low the core drives mem_we low and mem_addr to 0. After release, the first fetch reads address 0 and all sixteen registers hold zero.
- R2: Each instruction is fetched from the program counter, which then advances by one word. Consecutive instructions are fetched from consecutive addresses unless a branch or jump intervenes.
- R3: Opcodes 0000 add, 0001 subtract, 0010 AND and 0011 OR write rs op rt into register rd (field [3:0]), using 16-bit wrap-around arithmetic.
- R4: Opcode 1101 writes rs plus the sign-extended 4-bit field [3:0] into register rt.
- R5: Opcode 0101 (load) writes into rt the memory word at rs plus the sign-extended field [3:0]. Opcode 0110 (store) writes rt to that address, taking the low 12 bits of the sum. mem_we is high for exactly one cycle per store and at no other time.
- R6: Register 0 reads as zero. Writes to it have no effect.
- R7: Opcodes 0111 equal, 1000 not-equal, 1001 less, 1010 less-or-equal, 1011 greater and 1100 greater-or-equal compare rs against rt as signed values. When taken, the next fetch is from (branch address + 1) plus the sign-extended 4-bit offset. Otherwise execution continues in sequence.
- R8: Opcode 1111 continues fetching at the 12-bit absolute address in [11:0].
- R9: Opcodes 0100 and 1110 change no register and no memory, and take two cycles.
- R10: Cycle counts per instruction are: no-op 2, branch and jump 3, register operation, add-immediate and store 4, and load 5. A store's write happens in its fourth cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Word address for fetch, load or store |
| mem_wdata | output | 16 | Store data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Combinational read data from memory |

## Verification
The shared ALU forms the branch target in the decode cycle. In the following cycle it is reused to compare the two operands, and the comparison flags and the stored target then meet in that single cycle that updates the program counter. A wrong select lets the compare result overwrite the target, or the pending target leak into a not-taken path. The bench provokes this with all six branch forms on random operands, on equal operands, and on the signed boundary pair 0x8000/0x7FFF. It also runs a loop that branches backwards with offset -5. The outcome is judged from marker values that the program stores on the taken and fall-through paths, and each is compared against a signed comparison computed in the bench.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
   localparam int OPC_W = 4;

   typedef enum logic [3:0] {
      OP_ADD = 4'b0000, OP_SUB = 4'b0001, OP_AND = 4'b0010, OP_OR = 4'b0011,
      OP_NOP = 4'b0100, OP_LW = 4'b0101, OP_SW = 4'b0110, OP_BEQ = 4'b0111,
      OP_BNE = 4'b1000, OP_BLT = 4'b1001, OP_BLE = 4'b1010, OP_BGT = 4'b1011,
      OP_BGE = 4'b1100, OP_ADDI = 4'b1101, OP_SPARE = 4'b1110, OP_JMP = 4'b1111
   } opc_e;

   typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} aluop_e;

   typedef enum logic [3:0] {
      S_FETCH, S_DECODE, S_EXEC_R, S_EXEC_I, S_WB,
      S_MEMRD, S_WBMEM, S_MEMWR, S_BRANCH, S_JUMP
   } state_e;

   typedef enum logic       {A_PC, A_REG} asrc_e;
   typedef enum logic [1:0] {B_REG, B_ONE, B_IMM} bsrc_e;
   typedef enum logic [1:0] {PCS_ALU, PCS_TGT, PCS_JMP} pcsrc_e;

   typedef struct packed {
      logic   pc_we;
      pcsrc_e pc_src;
      logic   ir_we;
      logic   mdr_we;
      logic   ab_we;
      logic   aout_we;
      asrc_e  a_src;
      bsrc_e  b_src;
      aluop_e op;
      logic   rf_we;
      logic   rf_to_rd;
      logic   rf_from_mdr;
      logic   addr_from_pc;
      logic   mem_we;
   } ctl_t;
endpackage

// File: rtl/mc16_alu.sv
module mc16_alu
   import mc16_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  aluop_e       op,
   output logic [W-1:0] y,
   output logic         eq,
   output logic         lt
);
   logic [W-1:0] diff;
   logic         ovf;

   assign diff = a - b;
   assign ovf  = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
   assign eq   = (diff == '0);
   assign lt   = diff[W-1] ^ ovf;

   always_comb begin
      unique case (op)
         ALU_ADD: y = a + b;
         ALU_SUB: y = diff;
         ALU_AND: y = a & b;
         default: y = a | b;
      endcase
   end
endmodule

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
   parameter int W = 16,
   parameter int N = 16,
   localparam int AW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] ra1,
   output logic [W-1:0]  rd1,
   input  logic [AW-1:0] ra2,
   output logic [W-1:0]  rd2
);
   logic [N*W-1:0] flat;

   for (genvar i = 0; i < N; i++) begin : g_ent
      if (i == 0) begin : g_zero
         assign flat[0 +: W] = '0;
      end else begin : g_reg
         logic [W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          q <= '0;
            else if (we && waddr == AW'(i))      q <= wdata;
         end
         assign flat[i*W +: W] = q;
      end
   end

   assign rd1 = flat[ra1*W +: W];
   assign rd2 = flat[ra2*W +: W];
endmodule

// File: rtl/mc16_ctrl.sv
module mc16_ctrl
   import mc16_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] opc,
   input  logic             eq,
   input  logic             lt,
   output ctl_t             ctl,
   output state_e           st
);
   state_e st_q, st_d;
   opc_e   op;
   logic   take;

   assign op = opc_e'(opc);
   assign st = st_q;

   always_comb begin
      unique case (op)
         OP_BEQ:  take = eq;
         OP_BNE:  take = !eq;
         OP_BLT:  take = lt;
         OP_BLE:  take = lt | eq;
         OP_BGT:  take = !(lt | eq);
         OP_BGE:  take = !lt;
         default: take = 1'b0;
      endcase
   end

   always_comb begin
      ctl  = '0;
      st_d = S_FETCH;
      unique case (st_q)
         S_FETCH: begin
            ctl.addr_from_pc = 1'b1;
            ctl.ir_we        = 1'b1;
            ctl.a_src        = A_PC;
            ctl.b_src        = B_ONE;
            ctl.op           = ALU_ADD;
            ctl.pc_we        = 1'b1;
            ctl.pc_src       = PCS_ALU;
            st_d             = S_DECODE;
         end
         S_DECODE: begin
            ctl.ab_we   = 1'b1;
            ctl.a_src   = A_PC;
            ctl.b_src   = B_IMM;
            ctl.op      = ALU_ADD;
            ctl.aout_we = 1'b1;
            unique case (op)
               OP_ADD, OP_SUB, OP_AND, OP_OR:          st_d = S_EXEC_R;
               OP_ADDI, OP_LW, OP_SW:                   st_d = S_EXEC_I;
               OP_BEQ, OP_BNE, OP_BLT, OP_BLE,
               OP_BGT, OP_BGE:                          st_d = S_BRANCH;
               OP_JMP:                                  st_d = S_JUMP;
               default:                                 st_d = S_FETCH;
            endcase
         end
         S_EXEC_R: begin
            ctl.a_src   = A_REG;
            ctl.b_src   = B_REG;
            ctl.op      = aluop_e'(opc[1:0]);
            ctl.aout_we = 1'b1;
            st_d        = S_WB;
         end
         S_EXEC_I: begin
            ctl.a_src   = A_REG;
            ctl.b_src   = B_IMM;
            ctl.op      = ALU_ADD;
            ctl.aout_we = 1'b1;
            st_d        = (op == OP_LW) ? S_MEMRD : (op == OP_SW) ? S_MEMWR : S_WB;
         end
         S_WB: begin
            ctl.rf_we    = 1'b1;
            ctl.rf_to_rd = (opc[3:2] == 2'b00);
         end
         S_MEMRD: begin
            ctl.mdr_we = 1'b1;
            st_d       = S_WBMEM;
         end
         S_WBMEM: begin
            ctl.rf_we       = 1'b1;
            ctl.rf_from_mdr = 1'b1;
         end
         S_MEMWR: ctl.mem_we = 1'b1;
         S_BRANCH: begin
            ctl.a_src  = A_REG;
            ctl.b_src  = B_REG;
            ctl.op     = ALU_SUB;
            ctl.pc_we  = take;
            ctl.pc_src = PCS_TGT;
         end
         S_JUMP: begin
            ctl.pc_we  = 1'b1;
            ctl.pc_src = PCS_JMP;
         end
         default: st_d = S_FETCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= S_FETCH;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/mc_core16.sv
module mc_core16
   import mc16_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12,
   parameter int NREG   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int RIDX_W = $clog2(NREG);
   localparam int FLD_W  = 4;

   if (DATA_W != 16) begin : g_bad_data
      $error("mc_core16: DATA_W must be 16 for the four-field word");
   end
   if (ADDR_W != 12) begin : g_bad_addr
      $error("mc_core16: ADDR_W must match the 12-bit jump field");
   end
   if (NREG != 16) begin : g_bad_nreg
      $error("mc_core16: NREG must be 16 for 4-bit register fields");
   end

   ctl_t              ctl;
   state_e            st;
   logic [ADDR_W-1:0] pc_q;
   logic [DATA_W-1:0] ir_q, mdr_q, ra_q, rb_q, aout_q;
   logic [DATA_W-1:0] a_in, b_in, alu_y, rd1, rd2, imm_x, rf_wdata;
   logic [RIDX_W-1:0] rs, rt, rd, rf_waddr;
   logic              eq, lt;

   assign rs    = ir_q[11:8];
   assign rt    = ir_q[7:4];
   assign rd    = ir_q[3:0];
   assign imm_x = {{(DATA_W-FLD_W){ir_q[FLD_W-1]}}, ir_q[FLD_W-1:0]};

   mc16_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .opc(ir_q[DATA_W-1 -: OPC_W]),
      .eq(eq), .lt(lt), .ctl(ctl), .st(st)
   );

   assign a_in = (ctl.a_src == A_PC) ? {{(DATA_W-ADDR_W){1'b0}}, pc_q} : ra_q;

   always_comb begin
      unique case (ctl.b_src)
         B_REG:   b_in = rb_q;
         B_ONE:   b_in = DATA_W'(1);
         default: b_in = imm_x;
      endcase
   end

   mc16_alu #(.W(DATA_W)) u_alu (
      .a(a_in), .b(b_in), .op(ctl.op), .y(alu_y), .eq(eq), .lt(lt)
   );

   assign rf_waddr = ctl.rf_to_rd    ? rd    : rt;
   assign rf_wdata = ctl.rf_from_mdr ? mdr_q : aout_q;

   mc16_regfile #(.W(DATA_W), .N(NREG)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(ctl.rf_we), .waddr(rf_waddr),
      .wdata(rf_wdata), .ra1(rs), .rd1(rd1), .ra2(rt), .rd2(rd2)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= '0;
         ir_q   <= '0;
         mdr_q  <= '0;
         ra_q   <= '0;
         rb_q   <= '0;
         aout_q <= '0;
      end else begin
         if (ctl.pc_we) begin
            unique case (ctl.pc_src)
               PCS_ALU: pc_q <= alu_y[ADDR_W-1:0];
               PCS_TGT: pc_q <= aout_q[ADDR_W-1:0];
               default: pc_q <= ir_q[ADDR_W-1:0];
            endcase
         end
         if (ctl.ir_we)   ir_q   <= mem_rdata;
         if (ctl.mdr_we)  mdr_q  <= mem_rdata;
         if (ctl.aout_we) aout_q <= alu_y;
         if (ctl.ab_we) begin
            ra_q <= rd1;
            rb_q <= rd2;
         end
      end
   end

   assign mem_addr  = ctl.addr_from_pc ? pc_q : aout_q[ADDR_W-1:0];
   assign mem_wdata = rb_q;
   assign mem_we    = ctl.mem_we;
endmodule

// File: rtl/mc_core16_chk.sv
module mc_core16_chk
   import mc16_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input state_e            st,
   input logic [ADDR_W-1:0] pc,
   input logic [DATA_W-1:0] ir,
   input logic              mem_we
);
   AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
      st == S_FETCH |=> st == S_DECODE);                                    // R2
   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      st == S_FETCH |=> pc == $past(pc) + 1'b1);                             // R2
   AST_DECODE_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      st == S_DECODE |=> $stable(pc));                                       // R7
   AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      st == S_JUMP |=> pc == $past(ir[ADDR_W-1:0]));                         // R8
   AST_STORE_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> st == S_FETCH);                                             // R5
   AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);                                                   // R5
   AST_NOP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_DECODE && (ir[DATA_W-1 -: OPC_W] == OP_NOP ||
                          ir[DATA_W-1 -: OPC_W] == OP_SPARE)) |=> st == S_FETCH); // R9
endmodule

bind mc_core16 mc_core16_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .st(st), .pc(pc_q), .ir(ir_q), .mem_we(mem_we)
);

// File: tb/mc_core16_tb.sv
module mc_core16_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] mem_addr;
   logic [15:0] mem_wdata, mem_rdata;
   logic        mem_we;
   logic [15:0] mem [256];

   int checks = 0;
   int errors = 0;
   int nwr;
   int          wcyc [16];
   logic [11:0] wadr [16];
   logic [15:0] wdat [16];
   logic [11:0] alog [128];

   always #(CLK_PERIOD/2) clk = ~clk;

   mc_core16 u_dut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_rdata(mem_rdata)
   );

   assign mem_rdata = mem[mem_addr[7:0]];
   always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

   function automatic logic [15:0] enc(input logic [3:0] o, a, b, c);
      return {o, a, b, c};
   endfunction

   function automatic logic [15:0] ref_alu(input logic [1:0] o, input logic [15:0] a, b);
      case (o)
         2'd0:    return a + b;
         2'd1:    return a - b;
         2'd2:    return a & b;
         default: return a | b;
      endcase
   endfunction

   function automatic bit ref_br(input logic [3:0] o, input logic [15:0] a, b);
      case (o)
         4'd7:    return a == b;
         4'd8:    return a != b;
         4'd9:    return $signed(a) <  $signed(b);
         4'd10:   return $signed(a) <= $signed(b);
         4'd11:   return $signed(a) >  $signed(b);
         default: return $signed(a) >= $signed(b);
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] <= 16'h4000;
   endtask

   task automatic start();
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(mem_we == 1'b0, "R1 reset we", 32'(mem_we), 0);
      chk(mem_addr == 12'h000, "R1 reset addr", 32'(mem_addr), 0);
      rst_n = 1'b1;
   endtask

   task automatic run(input int ncyc);
      nwr = 0;
      for (int c = 0; c < ncyc; c++) begin
         if (c < 128) alog[c] = mem_addr;
         if (mem_we && nwr < 16) begin
            wcyc[nwr] = c;
            wadr[nwr] = mem_addr;
            wdat[nwr] = mem_wdata;
            nwr++;
         end
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h1357_2468));

      // Directed: mixed classes, cycle counts, r0 immunity
      clear_mem();
      mem[0]  <= enc(4'h4, 0, 0, 0);
      mem[1]  <= enc(4'hD, 0, 1, 4'hD);
      mem[2]  <= enc(4'h0, 1, 1, 2);
      mem[3]  <= enc(4'h5, 0, 3, 2);
      mem[4]  <= enc(4'h7, 1, 2, 5);
      mem[5]  <= {4'hF, 12'd6};
      mem[6]  <= enc(4'h6, 0, 3, 4'h8);
      mem[7]  <= enc(4'h6, 0, 2, 4'h9);
      mem[8]  <= enc(4'hD, 0, 0, 5);
      mem[9]  <= enc(4'h6, 0, 0, 4'hA);
      mem[10] <= {4'hF, 12'd10};
      start();
      run(50);
      chk(alog[0] == 12'h000, "R1 first fetch", 32'(alog[0]), 0);
      chk(alog[2] == 12'h001, "R2 next fetch", 32'(alog[2]), 1);
      chk(alog[6] == 12'h002, "R2 third fetch", 32'(alog[6]), 2);
      chk(nwr == 3, "R5 store count", 32'(nwr), 3);
      chk(wcyc[0] == 24, "R10 store cycle", 32'(wcyc[0]), 24);
      chk(wadr[0] == 12'hFF8, "R5 store addr", 32'(wadr[0]), 32'hFF8);
      chk(wdat[0] == 16'h0112, "R5 load data", 32'(wdat[0]), 32'h0112);
      chk(wcyc[1] == 28, "R10 second store", 32'(wcyc[1]), 28);
      chk(wdat[1] == 16'hFFFA, "R3 R4 add of addi", 32'(wdat[1]), 32'hFFFA);
      chk(wcyc[2] == 36, "R10 third store", 32'(wcyc[2]), 36);
      chk(wdat[2] == 16'h0000, "R6 r0 write ignored", 32'(wdat[2]), 0);

      // Directed: spare no-op and far jump
      clear_mem();
      mem[0]    <= 16'hE123;
      mem[1]    <= {4'hF, 12'hABC};
      mem[8'hBC] <= enc(4'hD, 0, 6, 7);
      mem[8'hBD] <= enc(4'h6, 0, 6, 4'h8);
      mem[8'hBE] <= {4'hF, 12'hABE};
      start();
      run(30);
      chk(alog[5] == 12'hABC, "R8 jump target", 32'(alog[5]), 32'hABC);
      chk(nwr == 1 && wcyc[0] == 12, "R9 spare no-op timing", 32'(wcyc[0]), 12);
      chk(wdat[0] == 16'h0007, "R9 R4 value", 32'(wdat[0]), 7);

      // Directed: backward branch loop (offset -5)
      clear_mem();
      mem[0] <= enc(4'hD, 0, 1, 3);
      mem[4] <= enc(4'hD, 2, 2, 1);
      mem[8] <= enc(4'h8, 2, 1, 4'hB);
      mem[9] <= enc(4'h6, 0, 2, 4'h8);
      mem[10] <= {4'hF, 12'd10};
      start();
      run(120);
      chk(nwr == 1 && wdat[0] == 16'd3, "R7 backward loop", 32'(wdat[0]), 3);

      // Random: ALU ops, addi, all six branches
      for (int it = 0; it < 60; it++) begin
         logic [3:0]  bop, imm;
         logic [1:0]  rop;
         logic [15:0] a, b, e4, e5, e3;
         bop = 4'(7 + it % 6);
         rop = 2'($urandom_range(0, 3));
         imm = 4'($urandom_range(0, 15));
         a   = 16'($urandom);
         b   = 16'($urandom);
         if (it < 6) begin
            a = 16'h8000;
            b = 16'h7FFF;
         end else if (it < 12 || $urandom_range(0, 3) == 0) begin
            b = a;
         end
         e4 = ref_alu(rop, a, b);
         e5 = a + {{12{imm[3]}}, imm};
         e3 = ref_br(bop, a, b) ? 16'd2 : 16'd1;
         clear_mem();
         mem[0]  <= enc(4'h5, 0, 1, 4'h8);
         mem[1]  <= enc(4'h5, 0, 2, 4'h9);
         mem[2]  <= enc({2'b00, rop}, 1, 2, 4);
         mem[3]  <= enc(4'h6, 0, 4, 4'hB);
         mem[4]  <= enc(4'hD, 1, 5, imm);
         mem[5]  <= enc(4'h6, 0, 5, 4'hC);
         mem[6]  <= enc(bop, 1, 2, 2);
         mem[7]  <= enc(4'hD, 0, 3, 1);
         mem[8]  <= {4'hF, 12'd10};
         mem[9]  <= enc(4'hD, 0, 3, 2);
         mem[10] <= enc(4'h6, 0, 3, 4'hA);
         mem[11] <= {4'hF, 12'd11};
         mem[8'hF8] <= a;
         mem[8'hF9] <= b;
         start();
         run(70);
         chk(mem[8'hFB] == e4, "R3 random alu", 32'(mem[8'hFB]), 32'(e4));
         chk(mem[8'hFC] == e5, "R4 random addi", 32'(mem[8'hFC]), 32'(e5));
         chk(mem[8'hFA] == e3, "R7 random branch", 32'(mem[8'hFA]), 32'(e3));
         chk(wcyc[0] == 17, "R10 load and alu timing", 32'(wcyc[0]), 17);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule